// File: doc/BRIEF.md
# Strobe-Framed Byte ROM

This block models a 2048-byte read-only memory read through a strobe-framed access cycle. Each access starts when the active-low select strobe falls. At that instant the 11-bit address is frozen in an internal register. Later changes on the address pins leave the access alone until select goes high and falls again. Data is fetched only after the active-low read strobe falls while select is held low. The byte is then presented to a three-state byte bus. The block reports that bus as a data value, a drive flag and a valid flag.

Both strobes and the program-enable level are asynchronous. A fast system clock samples each of them through a two-stage synchroniser, and edges are detected on the synchronised copies. The content needs no file. A fixed function computes it from the row index (address bits 10..4) and the column group (bits 3..0), so any consumer can recompute every byte. Holding program-enable low inhibits all reads.

Top module: `strobe_rom`

## Requirements
- R1: While rst_n is low and right after it, drive_en, data_valid and data_out are all 0.
- R2: The byte for address a is 8'hA5 XOR {1'b0, a[10:4]} XOR rotl1({a[3:0], a[3:0]}), where rotl1 rotates an 8-bit value left by one bit.
- R3: The address latched is the one on addr_in at the clock edge that first samples ce_n low. Changes on addr_in after that have no effect on the access.
- R4: When ce_n and oe_n go low together (sampled first at edge k), drive_en rises at edge k+2. data_valid and the byte appear at edge k+3.
- R5: With ce_n low and oe_n high, drive_en and data_valid are 0, and data_valid never stands without drive_en.
- R6: With ce_n high, drive_en and data_valid are 0 whatever oe_n does. They clear by the second edge after ce_n is first sampled high.
- R7: While ce_n stays low, a new fall of oe_n reads the same latched word again, even if addr_in has changed.
- R8: While prog_en is low, no read starts. Dropping prog_en during a read clears drive_en and data_valid by the second edge after it is sampled.
- R9: If oe_n is already low when ce_n falls, no data is delivered: data_valid stays 0 until oe_n rises and falls again.
- R10: data_out is 0 whenever drive_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 11 | Word address, captured when ce_n falls |
| ce_n | input | 1 | Active-low select strobe, asynchronous |
| oe_n | input | 1 | Active-low read strobe, asynchronous |
| prog_en | input | 1 | High for normal reads; low inhibits reads |
| data_out | output | 8 | Byte driven on the bus, 0 when floating |
| drive_en | output | 1 | High while the bus would be driven |
| data_valid | output | 1 | High while data_out holds the fetched byte |

## Verification
On every cycle, the assertions check the following:
- the latched address stays put between select falls;
- data_valid only rises one cycle after a read request;
- valid data never stands without drive;
- select high or program-enable low quiets the bus;
- the bus reads zero whenever it floats.

Only the bench scenarios can show these:
- the content formula across all 2048 addresses;
- the exact latency from the strobe inputs;
- the address being ignored after capture;
- re-reads on a read-strobe toggle;
- the missing delivery when the read strobe was already low at select time.

// File: rtl/strobe_rom.sv
module strobe_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter logic [DATA_W-1:0] SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_en,
  output logic [DATA_W-1:0] data_out,
  output logic              drive_en,
  output logic              data_valid
);
  localparam int REP = DATA_W / COL_W;

  function automatic logic [DATA_W-1:0] rom_byte(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r, c;
    r = DATA_W'(a[ADDR_W-1:COL_W]);
    c = {REP{a[COL_W-1:0]}};
    return SEED ^ r ^ {c[DATA_W-2:0], c[DATA_W-1]};
  endfunction

  logic [1:0]        ce_sy, oe_sy, pe_sy;
  logic              ce_d, oe_d;
  logic [ADDR_W-1:0] a_m, a_s, addr_lat;
  logic              rd_pend;
  logic [DATA_W-1:0] data_q;

  wire ce_s    = ce_sy[1];
  wire oe_s    = oe_sy[1];
  wire pe_s    = pe_sy[1];
  wire ce_fall = ce_d & ~ce_s;
  wire oe_fall = oe_d & ~oe_s;
  wire en_now  = ~ce_s & ~oe_s & pe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy      <= 2'b11;
      oe_sy      <= 2'b11;
      pe_sy      <= 2'b00;
      ce_d       <= 1'b1;
      oe_d       <= 1'b1;
      a_m        <= '0;
      a_s        <= '0;
      addr_lat   <= '0;
      rd_pend    <= 1'b0;
      data_q     <= '0;
      drive_en   <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      ce_sy    <= {ce_sy[0], ce_n};
      oe_sy    <= {oe_sy[0], oe_n};
      pe_sy    <= {pe_sy[0], prog_en};
      ce_d     <= ce_s;
      oe_d     <= oe_s;
      a_m      <= addr_in;
      a_s      <= a_m;
      if (ce_fall) addr_lat <= a_s;
      rd_pend  <= oe_fall & ~ce_s & pe_s;
      if (rd_pend) data_q <= rom_byte(addr_lat);
      drive_en   <= en_now;
      data_valid <= en_now & (rd_pend | data_valid);
    end
  end

  assign data_out = data_valid ? data_q : '0;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(addr_lat)); // R3
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(rd_pend)); // R4
  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> drive_en); // R5
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> (!data_valid && !drive_en)); // R6
  AST_PROG_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_s |=> (!data_valid && !drive_en)); // R8
  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (data_out == '0)); // R10
endmodule

// File: tb/test_strobe_rom.sv
module test_strobe_rom;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr_in = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, prog_en = 1'b1;
  logic [7:0]  data_out;
  logic        drive_en, data_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  strobe_rom i_strobe_rom (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce_n(ce_n), .oe_n(oe_n),
    .prog_en(prog_en), .data_out(data_out), .drive_en(drive_en), .data_valid(data_valid)
  );

  // bit 11: prog_en level, bits 10..0: address
  localparam logic [11:0] VEC [12] = '{
    12'h800, 12'hFFF, 12'h80F, 12'hFF0, 12'h955, 12'hAAA,
    12'h8F1, 12'h123, 12'h7FF, 12'hC3C, 12'h000, 12'hB7E
  };

  function automatic logic [7:0] exp_byte(input logic [10:0] a);
    logic [7:0] c;
    c = {a[3:0], a[3:0]};
    return 8'hA5 ^ {1'b0, a[10:4]} ^ {c[6:0], c[7]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [10:0] a, input logic pe);
    addr_in = a; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(3);
    chk("R4 drive at k+2", {7'b0, drive_en}, {7'b0, pe});
    chk("R4 no valid at k+2", {7'b0, data_valid}, 8'h00);
    wait_n(1);
    chk("R4 valid at k+3", {7'b0, data_valid}, {7'b0, pe});
    chk("R2 byte", data_out, pe ? exp_byte(a) : 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(3);
    chk("R6 standby after cycle", {6'b0, drive_en, data_valid}, 8'h00);
    chk("R10 float zero", data_out, 8'h00);
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset outputs", {6'b0, drive_en, data_valid}, 8'h00);
    chk("R1 reset data", data_out, 8'h00);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 after reset", {6'b0, drive_en, data_valid}, 8'h00);

    foreach (VEC[i]) begin
      prog_en = VEC[i][11];
      wait_n(3);
      access(VEC[i][10:0], VEC[i][11]);
    end
    prog_en = 1'b1;
    wait_n(3);

    for (int a = 0; a < 2048; a++) access(11'(a), 1'b1);

    // R3: address change after capture is ignored
    addr_in = 11'h2C7; ce_n = 1'b0;
    wait_n(3);
    addr_in = 11'h531;
    wait_n(2);
    chk("R5 no drive with G high", {6'b0, drive_en, data_valid}, 8'h00);
    oe_n = 1'b0;
    wait_n(4);
    chk("R3 latched address used", data_out, exp_byte(11'h2C7));
    oe_n = 1'b1;
    wait_n(3);
    chk("R5 G high disables", {6'b0, drive_en, data_valid}, 8'h00);
    // R7: re-read with E held low
    addr_in = 11'h7A0; oe_n = 1'b0;
    wait_n(4);
    chk("R7 re-read valid", {7'b0, data_valid}, 8'h01);
    chk("R7 same word", data_out, exp_byte(11'h2C7));
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(3);

    // R6: G low with E high
    oe_n = 1'b0;
    wait_n(6);
    chk("R6 E high ignores G", {6'b0, drive_en, data_valid}, 8'h00);
    // R9: G already low when E falls
    addr_in = 11'h0F0; ce_n = 1'b0;
    wait_n(6);
    chk("R9 drive without data", {7'b0, drive_en}, 8'h01);
    chk("R9 no valid", {7'b0, data_valid}, 8'h00);
    chk("R9 bus zero", data_out, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(3);

    // R8: inhibited read, then drop mid-read
    prog_en = 1'b0;
    wait_n(3);
    addr_in = 11'h321; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(6);
    chk("R8 inhibited", {6'b0, drive_en, data_valid}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; prog_en = 1'b1;
    wait_n(4);
    ce_n = 1'b0; oe_n = 1'b0;
    wait_n(4);
    chk("R8 read before drop", data_out, exp_byte(11'h321));
    prog_en = 1'b0;
    wait_n(3);
    chk("R8 drop clears", {6'b0, drive_en, data_valid}, 8'h00);
    chk("R10 zero after drop", data_out, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; prog_en = 1'b1;
    wait_n(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule